// File: doc/BRIEF.md
# Magic Packet Wake Detector

This block listens to the receive side of an Ethernet MAC one byte per transfer and decides whether the frame now passing is a remote wake request for this station. The station's 6-byte node ID and a global enable come in on plain input pins. The first transmitted byte of the ID is `node_id[47:40]` and the last is `node_id[7:0]`.

The byte stream is a valid/ready sink. `s_ready` is held high whenever reset is not asserted, so the block never applies back-pressure. A byte is consumed on every clock edge where `s_valid` and `s_ready` are both high (a "beat"). The source may drop `s_valid` between any two bytes, and such idle cycles have no effect on matching. `s_sof` marks the first destination byte of a frame. `s_eof` marks the last byte, which is the final CRC byte. `crc_ok` is the MAC's verdict and is sampled with the `s_eof` beat.

The first twelve bytes of a frame are the destination and source addresses. From byte 13 onward the block hunts for a sync run of 0xFF bytes followed directly by sixteen copies of the node ID. A single-cycle `wake` pulse reports a qualifying frame.

Top module: `mpd_wake_top`

## Requirements
- R1: `s_ready` is high in every cycle after reset is released. Cycles with `s_valid` low between bytes do not change the outcome for the frame.
- R2: The destination (the first 6 bytes) qualifies in two cases. Either it equals the node ID byte for byte, or bit 0 of its first byte is 1, which covers multicast and broadcast. Any other unicast destination never produces a wake.
- R3: A sync run is at least six consecutive 0xFF bytes, and longer runs are accepted. The first ID copy begins at the first non-0xFF byte after the run. A run of five is not enough.
- R4: The sync run must be followed by exactly sixteen back-to-back copies of the node ID (96 bytes). Any mismatching byte voids the attempt, and so does a copy count below sixteen.
- R5: A byte that breaks an ID-copy match is itself re-evaluated as the possible first byte of a new 0xFF run. A sync run that starts at the breaking byte can therefore still lead to a wake.
- R6: The search covers every byte from byte 13 of the frame (the first byte after the source address) up to, but not including, the `s_eof` byte. A pattern that begins immediately at byte 13 is found.
- R7: `wake` is high for exactly one cycle: the cycle after the `s_eof` beat. It is raised only if all of the following hold:
  - `en` and `crc_ok` were high on that beat;
  - the destination qualified;
  - the full pattern had completed before that beat.
- R8: Each `s_sof` beat discards all detection state. A pattern seen in an earlier frame that had no `s_eof` cannot make a later frame wake.
- R9: While `rst_n` is low, `wake` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Wake enable; when low no pulse is produced |
| node_id | input | 48 | Station ID, first transmitted byte in bits 47:40 |
| s_valid | input | 1 | Receive byte valid |
| s_ready | output | 1 | Sink ready, high whenever out of reset |
| s_data | input | 8 | Receive byte |
| s_sof | input | 1 | Beat carries the first byte of a frame |
| s_eof | input | 1 | Beat carries the last byte of a frame |
| crc_ok | input | 1 | Frame CRC good, meaningful on the `s_eof` beat |
| wake | output | 1 | One-cycle pulse after a qualifying frame ends |

## Verification
All hunting state is internal, so a fault in the sync counter, the copy counter or the in-copy index shows up only as a missing or extra `wake` pulse. That pulse appears one cycle after the `s_eof` beat of the affected frame, never earlier. The tests therefore choose frames whose only difference from a waking frame is the following:
- one sync byte too few;
- one copy too few;
- a single corrupted byte;
- a sync run that starts on the breaking byte.

Each such frame flips the pulse on exactly one counter boundary. A stuck flag that survives into the next frame shows as a spurious pulse at the end of that next frame.

// File: rtl/mpd_pkg.sv
package mpd_pkg;
  typedef logic [7:0] byte_t;
  localparam byte_t SYNC_BYTE = 8'hFF;
endpackage

// File: rtl/mpd_dest_filter.sv
module mpd_dest_filter
  import mpd_pkg::*;
#(
  parameter int ID_BYTES = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  beat,
  input  logic                  sof,
  input  byte_t                 data,
  input  logic [8*ID_BYTES-1:0] node_id,
  output logic                  dest_ok,
  output logic                  in_payload
);
  localparam int HDR   = 2 * ID_BYTES;
  localparam int POS_W = $clog2(HDR + 1);
  localparam logic [POS_W-1:0] POS_HDR = POS_W'(HDR);
  localparam logic [POS_W-1:0] POS_ID  = POS_W'(ID_BYTES);

  byte_t id_b [ID_BYTES];
  for (genvar g = 0; g < ID_BYTES; g++) begin : g_unpack
    assign id_b[g] = node_id[8*(ID_BYTES-1-g) +: 8];
  end

  logic [POS_W-1:0] pos_q;
  logic             mcast_q, ucast_q;
  byte_t            exp_b;

  always_comb begin
    exp_b = id_b[0];
    for (int k = 0; k < ID_BYTES; k++)
      if (pos_q == POS_W'(k)) exp_b = id_b[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      mcast_q <= 1'b0;
      ucast_q <= 1'b0;
    end else if (beat) begin
      if (sof) begin
        pos_q   <= POS_W'(1);
        mcast_q <= data[0];
        ucast_q <= (data == id_b[0]);
      end else begin
        if (pos_q < POS_ID) ucast_q <= ucast_q & (data == exp_b);
        if (pos_q < POS_HDR) pos_q <= pos_q + POS_W'(1);
      end
    end
  end

  assign dest_ok    = mcast_q | ucast_q;
  assign in_payload = (pos_q == POS_HDR);
endmodule

// File: rtl/mpd_pattern_hunter.sv
module mpd_pattern_hunter
  import mpd_pkg::*;
#(
  parameter int ID_BYTES = 6,
  parameter int SYNC_LEN = 6,
  parameter int COPIES   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  step,
  input  byte_t                 data,
  input  logic [8*ID_BYTES-1:0] node_id,
  output logic                  found
);
  localparam int TOTAL  = ID_BYTES * COPIES;
  localparam int SYNC_W = $clog2(SYNC_LEN + 1);
  localparam int IDX_W  = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1;
  localparam int CNT_W  = $clog2(TOTAL + 1);
  localparam logic [SYNC_W-1:0] SYNC_FULL = SYNC_W'(SYNC_LEN);
  localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(ID_BYTES - 1);
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(TOTAL - 1);
  localparam logic [IDX_W-1:0]  IDX_SECOND = (ID_BYTES > 1) ? IDX_W'(1) : '0;

  byte_t id_b [ID_BYTES];
  for (genvar g = 0; g < ID_BYTES; g++) begin : g_unpack
    assign id_b[g] = node_id[8*(ID_BYTES-1-g) +: 8];
  end

  logic [SYNC_W-1:0] sync_q, sync_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              in_id_q, in_id_n, found_q, found_n;
  logic              is_ff;
  byte_t             exp_b;

  always_comb begin
    exp_b = id_b[0];
    for (int k = 0; k < ID_BYTES; k++)
      if (idx_q == IDX_W'(k)) exp_b = id_b[k];
  end

  assign is_ff = (data == SYNC_BYTE);

  always_comb begin
    sync_n  = sync_q;
    idx_n   = idx_q;
    cnt_n   = cnt_q;
    in_id_n = in_id_q;
    found_n = found_q;
    if (clear) begin
      sync_n  = '0;
      idx_n   = '0;
      cnt_n   = '0;
      in_id_n = 1'b0;
      found_n = 1'b0;
    end else if (step && !found_q) begin
      if (in_id_q) begin
        if (data == exp_b) begin
          if (cnt_q == CNT_LAST) begin
            found_n = 1'b1;
            in_id_n = 1'b0;
          end else begin
            cnt_n = cnt_q + CNT_W'(1);
            idx_n = (idx_q == IDX_LAST) ? '0 : idx_q + IDX_W'(1);
          end
        end else begin
          in_id_n = 1'b0;
          sync_n  = is_ff ? SYNC_W'(1) : '0;
        end
      end else if (sync_q == SYNC_FULL && !is_ff) begin
        sync_n = '0;
        if (data == id_b[0]) begin
          in_id_n = 1'b1;
          cnt_n   = CNT_W'(1);
          idx_n   = IDX_SECOND;
        end
      end else if (is_ff) begin
        sync_n = (sync_q == SYNC_FULL) ? SYNC_FULL : sync_q + SYNC_W'(1);
      end else begin
        sync_n = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      in_id_q <= 1'b0;
      found_q <= 1'b0;
    end else begin
      sync_q  <= sync_n;
      idx_q   <= idx_n;
      cnt_q   <= cnt_n;
      in_id_q <= in_id_n;
      found_q <= found_n;
    end
  end

  assign found = found_q;
endmodule

// File: rtl/mpd_wake_top.sv
module mpd_wake_top
  import mpd_pkg::*;
#(
  parameter int ID_BYTES = 6,
  parameter int SYNC_LEN = 6,
  parameter int COPIES   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [8*ID_BYTES-1:0] node_id,
  input  logic                  s_valid,
  output logic                  s_ready,
  input  logic [7:0]            s_data,
  input  logic                  s_sof,
  input  logic                  s_eof,
  input  logic                  crc_ok,
  output logic                  wake
);
  logic beat, in_frame_q, dest_ok, in_payload, found, step, clear;

  assign s_ready = rst_n;
  assign beat    = s_valid & s_ready;
  assign clear   = beat & s_sof;
  assign step    = beat & ~s_sof & ~s_eof & in_frame_q & in_payload;

  mpd_dest_filter #(.ID_BYTES(ID_BYTES)) u_dest (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sof(s_sof), .data(s_data),
    .node_id(node_id), .dest_ok(dest_ok), .in_payload(in_payload)
  );

  mpd_pattern_hunter #(.ID_BYTES(ID_BYTES), .SYNC_LEN(SYNC_LEN), .COPIES(COPIES)) u_hunt (
    .clk(clk), .rst_n(rst_n), .clear(clear), .step(step), .data(s_data),
    .node_id(node_id), .found(found)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      wake       <= 1'b0;
    end else begin
      wake <= beat & s_eof & ~s_sof & in_frame_q & en & crc_ok & dest_ok & found;
      if (beat) begin
        if (s_sof && !s_eof)  in_frame_q <= 1'b1;
        else if (s_eof)       in_frame_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mpd_wake_chk.sv
module mpd_wake_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic s_valid,
  input logic s_ready,
  input logic s_sof,
  input logic s_eof,
  input logic crc_ok,
  input logic wake
);
  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n) s_ready); // R1
  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) wake |=> !wake); // R7
  AST_WAKE_AT_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(s_valid && s_ready && s_eof && !s_sof)); // R7
  AST_WAKE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(en && crc_ok)); // R7
  always @(negedge clk) if (!rst_n) AST_RST_QUIET: assert (!wake); // R9
endmodule

bind mpd_wake_top mpd_wake_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .s_valid(s_valid), .s_ready(s_ready),
  .s_sof(s_sof), .s_eof(s_eof), .crc_ok(crc_ok), .wake(wake)
);

// File: tb/sim_mpd_wake_top.sv
module sim_mpd_wake_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] MY_ID = 48'h021A3C4D5E6F;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic s_valid = 1'b0, s_sof = 1'b0, s_eof = 1'b0, crc_ok = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic s_ready, wake;
  int checks = 0, fails = 0;
  logic [7:0] frm [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mpd_wake_top u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .node_id(MY_ID), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .s_sof(s_sof), .s_eof(s_eof),
    .crc_ok(crc_ok), .wake(wake)
  );

  // dst: 0 own ID, 1 broadcast, 2 multicast, 3 foreign unicast; bad 31 = none
  typedef struct packed {
    logic [1:0] dst; logic [3:0] lead; logic [3:0] ffn; logic [4:0] copies;
    logic [4:0] bad; logic crc; logic ena; logic gap; logic exp;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{2'd0, 4'd3, 4'd6, 5'd16, 5'd31, 1'b1, 1'b1, 1'b0, 1'b1}, // R2 R3 R4 own unicast
    '{2'd1, 4'd2, 4'd6, 5'd16, 5'd31, 1'b1, 1'b1, 1'b0, 1'b1}, // R2 broadcast
    '{2'd2, 4'd4, 4'd6, 5'd16, 5'd31, 1'b1, 1'b1, 1'b0, 1'b1}, // R2 multicast
    '{2'd3, 4'd3, 4'd6, 5'd16, 5'd31, 1'b1, 1'b1, 1'b0, 1'b0}, // R2 foreign unicast
    '{2'd0, 4'd3, 4'd5, 5'd16, 5'd31, 1'b1, 1'b1, 1'b0, 1'b0}, // R3 short sync
    '{2'd0, 4'd1, 4'd9, 5'd16, 5'd31, 1'b1, 1'b1, 1'b0, 1'b1}, // R3 long sync
    '{2'd0, 4'd3, 4'd6, 5'd15, 5'd31, 1'b1, 1'b1, 1'b0, 1'b0}, // R4 15 copies
    '{2'd0, 4'd3, 4'd6, 5'd16, 5'd7,  1'b1, 1'b1, 1'b0, 1'b0}, // R4 corrupt copy
    '{2'd0, 4'd3, 4'd6, 5'd16, 5'd31, 1'b0, 1'b1, 1'b0, 1'b0}, // R7 crc bad
    '{2'd0, 4'd3, 4'd6, 5'd16, 5'd31, 1'b1, 1'b0, 1'b0, 1'b0}, // R7 disabled
    '{2'd0, 4'd0, 4'd6, 5'd16, 5'd31, 1'b1, 1'b1, 1'b0, 1'b1}, // R6 pattern at byte 13
    '{2'd1, 4'd2, 4'd6, 5'd16, 5'd31, 1'b1, 1'b1, 1'b1, 1'b1}  // R1 idle gaps
  };

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic push_id(input int bad_byte);
    for (int b = 0; b < 6; b++)
      frm.push_back(b == bad_byte ? 8'h00 : MY_ID[8*(5-b) +: 8]);
  endtask

  task automatic build(input logic [1:0] dst, input int lead, input int ffn,
                       input int copies, input int bad);
    frm.delete();
    for (int b = 0; b < 6; b++)
      case (dst)
        2'd0: frm.push_back(MY_ID[8*(5-b) +: 8]);
        2'd1: frm.push_back(8'hFF);
        2'd2: frm.push_back(b == 0 ? 8'h01 : 8'h5E);
        default: frm.push_back(b == 5 ? 8'h6E : MY_ID[8*(5-b) +: 8]);
      endcase
    for (int b = 0; b < 6; b++) frm.push_back(8'h20 + 8'(b));
    for (int b = 0; b < lead; b++) frm.push_back(8'h30 + 8'(b));
    for (int b = 0; b < ffn; b++) frm.push_back(8'hFF);
    for (int c = 0; c < copies; c++) push_id(c == bad ? 3 : -1);
  endtask

  task automatic add_tail();
    frm.push_back(8'h5A); frm.push_back(8'hA5);
    for (int b = 0; b < 4; b++) frm.push_back(8'hC0 + 8'(b));
  endtask

  task automatic send(input logic gap, input logic crc, input logic with_eof);
    for (int i = 0; i < frm.size(); i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = frm[i]; s_sof = (i == 0);
      s_eof = with_eof && (i == frm.size() - 1); crc_ok = crc;
      if (gap && i != frm.size() - 1) begin
        @(negedge clk); s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
      end
    end
  endtask

  task automatic finish_check(input logic exp, input string tag);
    @(negedge clk); s_valid = 1'b0; s_sof = 1'b0; s_eof = 1'b0;
    check(wake, exp, tag);
    @(negedge clk);
    check(wake, 1'b0, {tag, " R7 pulse width"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R7 actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(wake, 1'b0, "R9 wake low in reset");
    rst_n = 1'b1; en = 1'b1;
    @(negedge clk);
    check(s_ready, 1'b1, "R1 ready after reset");

    for (int v = 0; v < 12; v++) begin
      en = VECS[v].ena;
      build(VECS[v].dst, int'(VECS[v].lead), int'(VECS[v].ffn),
            int'(VECS[v].copies), VECS[v].bad == 5'd31 ? -1 : int'(VECS[v].bad));
      add_tail();
      send(VECS[v].gap, VECS[v].crc, 1'b1);
      finish_check(VECS[v].exp, $sformatf("vector %0d R2/R3/R4/R6/R7", v));
    end
    en = 1'b1;

    // R5: the byte breaking copy 4 is 0xFF and opens a new sync run
    build(2'd0, 2, 6, 3, -1);
    frm.push_back(8'hFF);
    for (int b = 0; b < 5; b++) frm.push_back(8'hFF);
    for (int c = 0; c < 16; c++) push_id(-1);
    add_tail();
    send(1'b0, 1'b1, 1'b1);
    finish_check(1'b1, "R5 restart on breaking byte");

    // R8: full pattern in an unterminated frame, then a plain frame
    build(2'd0, 2, 6, 16, -1);
    send(1'b0, 1'b1, 1'b0);
    build(2'd0, 2, 0, 0, -1);
    add_tail();
    send(1'b0, 1'b1, 1'b1);
    finish_check(1'b0, "R8 sof clears detection");

    // R8: afterwards a normal frame still wakes
    build(2'd0, 1, 6, 16, -1);
    add_tail();
    send(1'b0, 1'b1, 1'b1);
    finish_check(1'b1, "R8 recovery");

    // R9: reset asserted mid-frame keeps wake low
    build(2'd0, 1, 6, 16, -1);
    add_tail();
    send(1'b0, 1'b1, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    check(wake, 1'b0, "R9 reset mid-frame");
    rst_n = 1'b1;
    @(negedge clk);
    check(s_ready, 1'b1, "R1 ready after second reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule